// File: doc/BRIEF.md
# Byte-Lane Static Memory Controller

This block is a synchronous controller for an external asynchronous static memory of 65,536 words by 16 bits. A client issues single-word reads and writes through a valid/ready handshake. Each request carries a 16-bit word address, 16 bits of write data and a 2-bit lane mask. The controller turns each request into a chip-enable, write-enable or output-enable sequence. The memory has two active-low byte-lane strobes: the lower one covers data bits 7..0 and the upper one covers bits 15..8.

Every memory timing figure is a parameter counted in clock cycles: read wait cycles, write pulse width and post-read turnaround. The integrator sets each one to the ceiling of the required time divided by the clock period. The memory's data bus is shared. The controller presents it as a separate output word, an input word and a drive-enable, and it orders every change so that the memory and the controller never drive the bus together. Read data comes back with a one-clock valid pulse.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is held and right after it, chip enable, write enable, output enable and both lane strobes are high, the bus drive-enable is low, `reqReady` is high and `rspValid` is low.
- R2: An accepted read with a nonzero mask holds chip enable low, output enable low and write enable high for exactly READ_WAIT cycles, with the latched address on `memAddr` and the bus drive-enable low.
- R3: Read data is sampled in the last wait cycle. `rspValid` is high for one clock on the cycle after it. Any lane whose mask bit is 0 is returned as zero.
- R4: An accepted write with a nonzero mask holds write enable low and chip enable low for exactly WR_PULSE cycles, with output enable high and the write data driven. The memory stores the data on the rising edge of write enable.
- R5: In the cycle after write enable rises, address, lane strobes, write data and chip enable stay unchanged and the bus is still driven. The bus is released (drive-enable low) in the cycle after that.
- R6: Mask bit 0 selects the lower strobe (data bits 7..0) and mask bit 1 selects the upper strobe (bits 15..8). A strobe is low only during a memory cycle whose mask bit is 1.
- R7: The bus drive-enable is high only while output enable is high, so the controller never drives the bus while the memory may be driving it.
- R8: After a read, TURN_IDLE cycles pass with every memory control high before `reqReady` returns.
- R9: A request with mask 00 is accepted without any memory cycle. For a read, `rspValid` pulses on the next cycle with data zero. For a write, memory contents are unchanged. `reqReady` stays high in both cases.
- R10: A request is taken when `reqValid` and `reqReady` are both high. `reqReady` is low from the cycle after a nonzero-mask request is taken until the controller is idle again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller idle and able to take a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | Word address |
| reqWdata | input | 16 | Write data |
| reqMask | input | 2 | Lane mask: bit 0 lower byte, bit 1 upper byte |
| rspValid | output | 1 | Read data valid, one clock |
| rspRdata | output | 16 | Read data, disabled lanes zero |
| memAddr | output | 16 | Memory address |
| memChipEnN | output | 1 | Memory chip enable, active low |
| memWrEnN | output | 1 | Memory write enable, active low |
| memOutEnN | output | 1 | Memory output enable, active low |
| memLowByteN | output | 1 | Lower lane strobe, active low |
| memHighByteN | output | 1 | Upper lane strobe, active low |
| memDqOut | output | 16 | Data the controller drives onto the bus |
| memDqOe | output | 1 | Bus drive-enable for the controller |
| memDqIn | input | 16 | Data seen on the bus |

## Verification
The request is taken on clock edge E0. In the k-th cycle after E0, a read holds the memory strobes for k = 1..READ_WAIT, shows `rspValid` at k = READ_WAIT+1 and raises `reqReady` again at k = READ_WAIT+TURN_IDLE+1. A write holds write enable low for k = 1..WR_PULSE, holds everything for k = WR_PULSE+1 and releases the bus at k = WR_PULSE+2. A mask-00 read responds at k = 1. The bench samples on falling edges, checks every port at each of these k values, and checks the memory model's contents through later reads. A falling-edge monitor flags any cycle in which both the model and the controller drive the bus.

// File: rtl/asram_pkg.sv
package asram_pkg;
  localparam int DATA_W = 16;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_READ, ST_WRITE, ST_HOLD, ST_TURN
  } ctrlState_t;

  // strobes passed from control to datapath
  typedef struct packed {
    logic latch;     // register the accepted request
    logic capture;   // sample read data this cycle
    logic zeroRead;  // answer a mask-00 read with zero
    logic chipOn;    // memory cycle in progress
    logic readOn;    // output enable phase
    logic writeOn;   // write enable pulse
    logic drive;     // controller owns the bus
  } ctrlStrobes_t;
endpackage

// File: rtl/asram_fsm.sv
module asram_fsm
  import asram_pkg::*;
#(
  parameter int READ_WAIT = 2,
  parameter int WR_PULSE  = 2,
  parameter int TURN_IDLE = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic         reqWrite,
  input  logic [LANES-1:0] reqMask,
  output logic         reqReady,
  output ctrlStrobes_t strb
);
  localparam int MAXC  = (READ_WAIT > WR_PULSE) ?
                         ((READ_WAIT > TURN_IDLE) ? READ_WAIT : TURN_IDLE) :
                         ((WR_PULSE > TURN_IDLE) ? WR_PULSE : TURN_IDLE);
  localparam int CNT_W = $clog2(MAXC + 1);

  ctrlState_t state;
  logic [CNT_W-1:0] cnt;
  logic accept, anyLane, lastRead, lastWrite, lastTurn;

  assign reqReady  = (state == ST_IDLE);
  assign accept    = reqValid && reqReady;
  assign anyLane   = |reqMask;
  assign lastRead  = (cnt == CNT_W'(READ_WAIT - 1));
  assign lastWrite = (cnt == CNT_W'(WR_PULSE - 1));
  assign lastTurn  = (cnt == CNT_W'(TURN_IDLE - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (accept && anyLane) state <= reqWrite ? ST_WRITE : ST_READ;
        end
        ST_READ: begin
          cnt <= lastRead ? '0 : cnt + 1'b1;
          if (lastRead) state <= ST_TURN;
        end
        ST_WRITE: begin
          cnt <= lastWrite ? '0 : cnt + 1'b1;
          if (lastWrite) state <= ST_HOLD;
        end
        ST_HOLD: state <= ST_IDLE;
        ST_TURN: begin
          cnt <= lastTurn ? '0 : cnt + 1'b1;
          if (lastTurn) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb          = '0;
    strb.latch    = accept && anyLane;
    strb.zeroRead = accept && !anyLane && !reqWrite;
    strb.capture  = (state == ST_READ) && lastRead;
    strb.readOn   = (state == ST_READ);
    strb.writeOn  = (state == ST_WRITE);
    strb.chipOn   = (state == ST_READ) || (state == ST_WRITE) || (state == ST_HOLD);
    strb.drive    = (state == ST_WRITE) || (state == ST_HOLD);
  end

  // R10: a real request takes the controller busy on the next cycle
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && |reqMask) |=> !reqReady);
  // R9: a mask-00 request leaves the controller idle
  a_r9_zero_mask_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !(|reqMask)) |=> reqReady);
  // R8: turnaround follows the end of a read
  a_r8_turn_after_read: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strb.readOn) |-> !reqReady && !strb.chipOn);
endmodule

// File: rtl/asram_dp.sv
module asram_dp
  import asram_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [LANES-1:0]  reqMask,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memChipEnN,
  output logic              memWrEnN,
  output logic              memOutEnN,
  output logic [LANES-1:0]  memLaneN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ, rdataQ, laneData;
  logic [LANES-1:0]  maskQ;
  logic              rspQ;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign laneData[8*i +: 8] = maskQ[i] ? memDqIn[8*i +: 8] : 8'h00;
    assign memLaneN[i]        = !(strb.chipOn && maskQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      dataQ  <= '0;
      maskQ  <= '0;
      rdataQ <= '0;
      rspQ   <= 1'b0;
    end else begin
      if (strb.latch) begin
        addrQ <= reqAddr;
        dataQ <= reqWdata;
        maskQ <= reqMask;
      end
      rspQ <= strb.capture || strb.zeroRead;
      if (strb.capture)       rdataQ <= laneData;
      else if (strb.zeroRead) rdataQ <= '0;
    end
  end

  assign memAddr    = addrQ;
  assign memDqOut   = dataQ;
  assign memDqOe    = strb.drive;
  assign memChipEnN = !strb.chipOn;
  assign memWrEnN   = !strb.writeOn;
  assign memOutEnN  = !strb.readOn;
  assign rspValid   = rspQ;
  assign rspRdata   = rdataQ;

  // R7: never drive while the memory output may be on
  a_r7_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> memOutEnN);
  // R5: everything holds in the cycle write enable rises
  a_r5_hold_after_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrEnN) |-> !memChipEnN && memDqOe && $stable(memAddr)
                        && $stable(memDqOut) && $stable(memLaneN));
  // R5: bus released one cycle later
  a_r5_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWrEnN) |=> !memDqOe);
  // R3: the response is present when a read's output phase ends
  a_r3_rsp_at_read_end: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memOutEnN) |-> rspValid);
  // R4: write pulse always inside chip enable with output off
  a_r4_write_frame: assert property (@(posedge clk) disable iff (!rstN)
    !memWrEnN |-> !memChipEnN && memOutEnN);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int READ_WAIT = 2,
  parameter int WR_PULSE  = 2,
  parameter int TURN_IDLE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [15:0]       reqWdata,
  input  logic [1:0]        reqMask,
  output logic              rspValid,
  output logic [15:0]       rspRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memChipEnN,
  output logic              memWrEnN,
  output logic              memOutEnN,
  output logic              memLowByteN,
  output logic              memHighByteN,
  output logic [15:0]       memDqOut,
  output logic              memDqOe,
  input  logic [15:0]       memDqIn
);
  ctrlStrobes_t strb;
  logic [LANES-1:0] laneN;

  asram_fsm #(.READ_WAIT(READ_WAIT), .WR_PULSE(WR_PULSE), .TURN_IDLE(TURN_IDLE)) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqMask(reqMask), .reqReady(reqReady), .strb(strb)
  );

  asram_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .reqMask(reqMask), .memDqIn(memDqIn), .rspValid(rspValid), .rspRdata(rspRdata),
    .memAddr(memAddr), .memChipEnN(memChipEnN), .memWrEnN(memWrEnN),
    .memOutEnN(memOutEnN), .memLaneN(laneN), .memDqOut(memDqOut), .memDqOe(memDqOe)
  );

  assign memLowByteN  = laneN[0];
  assign memHighByteN = laneN[1];

  // R6: a lane strobe is only active inside chip enable
  a_r6_lane_in_chip: assert property (@(posedge clk) disable iff (!rstN)
    (!memLowByteN || !memHighByteN) |-> !memChipEnN);
endmodule

// File: tb/tb_asram_ctrl.sv
module tb_asram_ctrl;
  localparam int RW = 2, WP = 2, TI = 1;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic [1:0]  reqMask = '0;
  logic reqReady, rspValid, memChipEnN, memWrEnN, memOutEnN;
  logic memLowByteN, memHighByteN, memDqOe;
  logic [15:0] rspRdata, memAddr, memDqOut, memDqIn;

  int checks = 0, fails = 0;
  logic [15:0] model [256];
  logic [15:0] shadow [256];

  always #5 clk = ~clk;

  asram_ctrl #(.ADDR_W(16), .READ_WAIT(RW), .WR_PULSE(WP), .TURN_IDLE(TI)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata), .reqMask(reqMask),
    .rspValid(rspValid), .rspRdata(rspRdata), .memAddr(memAddr),
    .memChipEnN(memChipEnN), .memWrEnN(memWrEnN), .memOutEnN(memOutEnN),
    .memLowByteN(memLowByteN), .memHighByteN(memHighByteN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  // memory model: lanes not driven by the memory float to a marker value
  logic memDrvLo, memDrvHi;
  assign memDrvLo = !memChipEnN && memWrEnN && !memOutEnN && !memLowByteN;
  assign memDrvHi = !memChipEnN && memWrEnN && !memOutEnN && !memHighByteN;
  assign memDqIn[7:0]  = memDrvLo ? model[memAddr[7:0]][7:0]  : 8'hA5;
  assign memDqIn[15:8] = memDrvHi ? model[memAddr[7:0]][15:8] : 8'hA5;

  always @(posedge memWrEnN) begin
    if (memChipEnN === 1'b0) begin
      if (!memLowByteN)  model[memAddr[7:0]][7:0]  <= memDqOut[7:0];
      if (!memHighByteN) model[memAddr[7:0]][15:8] <= memDqOut[15:8];
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // R7 contention monitor
  always @(negedge clk) begin
    if (rstN && memDqOe && (memDrvLo || memDrvHi))
      chk("R7 bus driven by both sides", 1, 0);
  end

  task automatic issue(input logic wr, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] m);
    @(negedge clk);
    chk("R10 ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d; reqMask = m;
    @(negedge clk);
    reqValid = 1'b0; reqAddr = 16'hFFFF; reqWdata = 16'hFFFF; reqMask = 2'b11;
  endtask

  task automatic doWrite(input logic [15:0] a, input logic [15:0] d, input logic [1:0] m);
    issue(1'b1, a, d, m);
    for (int k = 1; k <= WP + 2; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= WP) begin
        chk("R4 write enable low", int'(memWrEnN), 0);
        chk("R4 chip enable low", int'(memChipEnN), 0);
        chk("R4 output enable high", int'(memOutEnN), 1);
        chk("R4 data driven", int'(memDqOe), 1);
        chk("R4 data", int'(memDqOut), int'(d));
        chk("R6 lower strobe", int'(memLowByteN), int'(!m[0]));
        chk("R6 upper strobe", int'(memHighByteN), int'(!m[1]));
        chk("R10 busy", int'(reqReady), 0);
      end else if (k == WP + 1) begin
        chk("R5 write enable high", int'(memWrEnN), 1);
        chk("R5 chip enable held", int'(memChipEnN), 0);
        chk("R5 bus still driven", int'(memDqOe), 1);
        chk("R5 address held", int'(memAddr), int'(a));
        chk("R5 data held", int'(memDqOut), int'(d));
        chk("R5 lower strobe held", int'(memLowByteN), int'(!m[0]));
      end else begin
        chk("R5 bus released", int'(memDqOe), 0);
        chk("R10 ready after write", int'(reqReady), 1);
      end
    end
    if (m[0]) shadow[a[7:0]][7:0]  = d[7:0];
    if (m[1]) shadow[a[7:0]][15:8] = d[15:8];
  endtask

  task automatic doRead(input logic [15:0] a, input logic [1:0] m);
    logic [15:0] exp;
    exp = {m[1] ? shadow[a[7:0]][15:8] : 8'h00, m[0] ? shadow[a[7:0]][7:0] : 8'h00};
    issue(1'b0, a, 16'h0, m);
    for (int k = 1; k <= RW + TI + 1; k++) begin
      if (k > 1) @(negedge clk);
      if (k <= RW) begin
        chk("R2 chip enable low", int'(memChipEnN), 0);
        chk("R2 output enable low", int'(memOutEnN), 0);
        chk("R2 write enable high", int'(memWrEnN), 1);
        chk("R2 address", int'(memAddr), int'(a));
        chk("R2 bus not driven", int'(memDqOe), 0);
        chk("R6 lower strobe", int'(memLowByteN), int'(!m[0]));
        chk("R6 upper strobe", int'(memHighByteN), int'(!m[1]));
        chk("R3 no early response", int'(rspValid), 0);
      end else if (k == RW + 1) begin
        chk("R3 response valid", int'(rspValid), 1);
        chk("R3 read data", int'(rspRdata), int'(exp));
        chk("R8 controls idle", int'({memChipEnN, memOutEnN, memWrEnN}), 7);
        chk("R8 not ready in turnaround", int'(reqReady), 0);
      end else begin
        chk("R3 single pulse", int'(rspValid), 0);
        chk("R8 ready after turnaround", int'(reqReady), int'(k == RW + TI + 1));
      end
    end
  endtask

  task automatic zeroMaskWrite(input logic [15:0] a);
    issue(1'b1, a, 16'h0000, 2'b00);
    for (int k = 1; k <= 3; k++) begin
      if (k > 1) @(negedge clk);
      chk("R9 no chip enable", int'(memChipEnN), 1);
      chk("R9 no bus drive", int'(memDqOe), 0);
      chk("R9 ready stays", int'(reqReady), 1);
    end
  endtask

  task automatic zeroMaskRead(input logic [15:0] a);
    issue(1'b0, a, 16'h0, 2'b00);
    chk("R9 zero read valid", int'(rspValid), 1);
    chk("R9 zero read data", int'(rspRdata), 0);
    chk("R9 no chip enable", int'(memChipEnN), 1);
    chk("R9 ready stays", int'(reqReady), 1);
    @(negedge clk);
    chk("R9 pulse ends", int'(rspValid), 0);
  endtask

  task automatic checkReset();
    @(negedge clk);
    chk("R1 controls high", int'({memChipEnN, memWrEnN, memOutEnN, memLowByteN, memHighByteN}), 31);
    chk("R1 bus released", int'(memDqOe), 0);
    chk("R1 response low", int'(rspValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(reqReady), 1);
    chk("R1 chip enable after reset", int'(memChipEnN), 1);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin model[i] = '0; shadow[i] = '0; end
    repeat (3) @(negedge clk);
    checkReset();
    doWrite(16'h0010, 16'h1234, 2'b11);
    doRead (16'h0010, 2'b11);
    doWrite(16'h0010, 16'hFFCD, 2'b01);
    doRead (16'h0010, 2'b11);
    doWrite(16'h0010, 16'h77EE, 2'b10);
    doRead (16'h0010, 2'b11);
    doRead (16'h0010, 2'b01);
    doRead (16'h0010, 2'b10);
    zeroMaskWrite(16'h0010);
    doRead (16'h0010, 2'b11);
    zeroMaskRead(16'h0010);
    doWrite(16'hABF3, 16'hBEEF, 2'b11);
    doWrite(16'h0011, 16'h5A5A, 2'b11);
    doRead (16'hABF3, 2'b11);
    doRead (16'h0011, 2'b10);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule